// File: doc/BRIEF.md
# Processor-Indexed Split Cache Lookup Controller

This controller sits in front of a last-level cache that is built from equal, separately enabled splits. A request carries a block address and the number of the processor that issued it. A programmable ownership table holds one bitmask per processor and marks which splits belong to it. A lookup first enables only the owner's splits, all in parallel. If none of them reports a hit, it enables every split it did not probe the first time. Only when that second probe also misses does it raise an off-chip request.

On a second-probe hit, the block is removed from the split where it was found and placed in a split owned by the requester, so one copy exists. On a full miss, the returned block is placed in a split owned by the requester. In both cases the destination is drawn pseudo-randomly from the requester's owned splits. The split arrays themselves are outside this block. Each split answers a chip select with a hit line in the same cycle.

The controller steps through five states. `ST_IDLE` waits for a request and leaves on acceptance to `ST_LOCAL`, or to `ST_REMOTE` if the requester owns nothing. `ST_LOCAL` probes the owned splits and goes to `ST_RESP` on a hit, otherwise to `ST_REMOTE`. `ST_REMOTE` probes the remaining splits and goes to `ST_RESP` on a hit, otherwise to `ST_MEM`. `ST_MEM` holds the off-chip request until it is acknowledged, then goes to `ST_RESP`. `ST_RESP` presents the result for one cycle and returns to `ST_IDLE`.

Top module: `split_lookup_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `split_cs`, `mem_req`, `fill_en` and `evict_en` are 0. Every ownership mask resets to empty.
- R2: Only one request is in flight at a time. `req_ready` is 0 from the cycle after acceptance until the response, and 1 again once the response is done. `rsp_valid` lasts exactly one cycle.
- R3: The first probe asserts `split_cs` on exactly the requester's owned splits. A hit there gives `rsp_kind` = 0 (local) and a `rsp_split` equal to the hitting split. The response comes 1 cycle after the first-probe cycle.
- R4: A split that is owned by several processors gives a local hit to each of them.
- R5: The second probe asserts `split_cs` on exactly the splits not probed in the first. A hit there gives `rsp_kind` = 1 (remote). The response comes 2 cycles after the first-probe cycle.
- R6: `mem_req` rises only after a second probe in which no enabled split hit. It stays high until `mem_ack`, and the response that follows has `rsp_kind` = 2 (miss).
- R7: On a miss, `fill_en` is 1 with the response, `evict_en` is 0, and `fill_split` is one of the requester's owned splits. `rsp_split` equals `fill_split`.
- R8: On a remote hit, `evict_en` is 1 and `evict_split` names the split that held the block. `fill_en` is 1 with `fill_split` in the requester's owned set, and `rsp_split` equals `fill_split`. A later request from the requester then hits locally.
- R9: A processor with an empty mask skips the first probe and probes all splits in one cycle, so a remote hit responds 1 cycle after acceptance. A fill for it may target any split.
- R10: A table write replaces one processor's whole mask. A write made while a lookup is running does not change that lookup's probe set, and it applies to the next request.
- R11: The fill destination comes from a free-running pseudo-random register, reduced modulo the number of owned splits. Repeated misses on a multi-split mask spread over more than one split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Ownership table write strobe |
| cfg_cpu | input | IDW | Processor whose mask is written |
| cfg_mask | input | NSPLIT | New ownership mask |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_cpu | input | IDW | Requesting processor |
| req_addr | input | AW | Block address |
| split_cs | output | NSPLIT | Chip selects to the splits |
| split_addr | output | AW | Address presented to the splits |
| split_hit | input | NSPLIT | Per-split hit lines, same cycle as the chip select |
| mem_req | output | 1 | Off-chip request, held until acknowledged |
| mem_addr | output | AW | Off-chip block address |
| mem_ack | input | 1 | Off-chip data returned |
| fill_en | output | 1 | Write the block into `fill_split` |
| fill_split | output | SW | Destination split |
| evict_en | output | 1 | Remove the block from `evict_split` |
| evict_split | output | SW | Split giving up the block |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_kind | output | 2 | 0 local hit, 1 remote hit, 2 miss |
| rsp_split | output | SW | Hitting split (local) or destination split |

## Verification
On every cycle, assertions check the following:
- two back-to-back probes never enable the same split;
- the off-chip request only rises after a probe with no hit;
- a fill always lands in the requester's owned set;
- a removal never comes from an owned split and always comes with a fill;
- the response is a single-cycle pulse that frees the controller.

The scenarios are needed for the rest:
- the hit class and its latency;
- a shared split giving local hits to two owners;
- a block moving and then being found locally;
- empty-mask handling;
- a mid-lookup table write being deferred;
- fills spreading over several splits.

// File: rtl/split_lkp_pkg.sv
`timescale 1ns/100ps
package split_lkp_pkg;
    typedef enum logic [1:0] {
        RES_LOCAL  = 2'd0,
        RES_REMOTE = 2'd1,
        RES_MISS   = 2'd2
    } result_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOCAL  = 3'd1,
        ST_REMOTE = 3'd2,
        ST_MEM    = 3'd3,
        ST_RESP   = 3'd4
    } state_e;
endpackage

// File: rtl/split_owner_table.sv
`timescale 1ns/100ps
module split_owner_table #(
    parameter int NCPU   = 4,
    parameter int NSPLIT = 8,
    localparam int IDW   = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDW-1:0]    wr_cpu,
    input  logic [NSPLIT-1:0] wr_mask,
    input  logic [IDW-1:0]    rd_cpu,
    output logic [NSPLIT-1:0] rd_mask
);
    logic [NCPU-1:0][NSPLIT-1:0] rows;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rows <= '0;
        else if (wr_en)
            rows[wr_cpu] <= wr_mask;
    end

    assign rd_mask = rows[rd_cpu];
endmodule

// File: rtl/split_lfsr.sv
`timescale 1ns/100ps
module split_lfsr #(
    parameter int          LW   = 8,
    parameter logic [LW-1:0] TAPS = 8'hB8,
    parameter logic [LW-1:0] SEED = 8'h5A
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [LW-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            value <= SEED;
        else
            value <= {1'b0, value[LW-1:1]} ^ (value[0] ? TAPS : '0);
    end

    // R11
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        value != '0);
endmodule

// File: rtl/split_pick.sv
`timescale 1ns/100ps
module split_pick #(
    parameter int NSPLIT = 8,
    parameter int LW     = 8,
    localparam int SW    = (NSPLIT > 1) ? $clog2(NSPLIT) : 1,
    localparam int CW    = $clog2(NSPLIT + 1)
) (
    input  logic [NSPLIT-1:0] owned,
    input  logic [LW-1:0]     rnd,
    output logic [SW-1:0]     idx
);
    logic [NSPLIT-1:0] cand;
    logic [CW-1:0]     cnt;
    logic [LW-1:0]     nth;
    logic [LW-1:0]     seen;
    logic              found;

    always_comb begin
        cand = (owned == '0) ? '1 : owned;
        cnt  = '0;
        for (int i = 0; i < NSPLIT; i++)
            cnt = cnt + CW'(cand[i]);
        nth   = rnd % LW'(cnt);
        seen  = '0;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NSPLIT; i++) begin
            if (cand[i]) begin
                if (!found && seen == nth) begin
                    idx   = SW'(i);
                    found = 1'b1;
                end
                seen = seen + 1'b1;
            end
        end
    end
endmodule

// File: rtl/split_lookup_ctrl.sv
`timescale 1ns/100ps
module split_lookup_ctrl import split_lkp_pkg::*; #(
    parameter int NCPU   = 4,
    parameter int NSPLIT = 8,
    parameter int AW     = 16,
    parameter int LW     = 8,
    localparam int IDW   = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int SW    = (NSPLIT > 1) ? $clog2(NSPLIT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDW-1:0]    cfg_cpu,
    input  logic [NSPLIT-1:0] cfg_mask,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IDW-1:0]    req_cpu,
    input  logic [AW-1:0]     req_addr,
    output logic [NSPLIT-1:0] split_cs,
    output logic [AW-1:0]     split_addr,
    input  logic [NSPLIT-1:0] split_hit,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_ack,
    output logic              fill_en,
    output logic [SW-1:0]     fill_split,
    output logic              evict_en,
    output logic [SW-1:0]     evict_split,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [SW-1:0]     rsp_split
);
    state_e            st, st_nx;
    result_e           kind_q, kind_nx;
    logic [NSPLIT-1:0] row_rd, row_q;
    logic [AW-1:0]     addr_q;
    logic [SW-1:0]     hit_q, hit_nx, tgt_q, tgt_nx, pick_idx;
    logic [LW-1:0]     rnd;
    logic [NSPLIT-1:0] loc_hits, rem_hits;

    function automatic logic [SW-1:0] lowest(input logic [NSPLIT-1:0] v);
        logic [SW-1:0] r;
        r = '0;
        for (int i = NSPLIT - 1; i >= 0; i--)
            if (v[i]) r = SW'(i);
        return r;
    endfunction

    split_owner_table #(.NCPU(NCPU), .NSPLIT(NSPLIT)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_cpu(cfg_cpu),
        .wr_mask(cfg_mask), .rd_cpu(req_cpu), .rd_mask(row_rd)
    );

    split_lfsr #(.LW(LW)) u_lfsr (.clk(clk), .rst_n(rst_n), .value(rnd));

    split_pick #(.NSPLIT(NSPLIT), .LW(LW)) u_pick (
        .owned(row_q), .rnd(rnd), .idx(pick_idx)
    );

    assign loc_hits = split_hit & row_q;
    assign rem_hits = split_hit & ~row_q;

    // state register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            kind_q <= RES_LOCAL;
            row_q  <= '0;
            addr_q <= '0;
            hit_q  <= '0;
            tgt_q  <= '0;
        end else begin
            st     <= st_nx;
            kind_q <= kind_nx;
            hit_q  <= hit_nx;
            tgt_q  <= tgt_nx;
            if (st == ST_IDLE && req_valid) begin
                row_q  <= row_rd;
                addr_q <= req_addr;
            end
        end
    end

    // next-state logic
    always_comb begin
        st_nx   = st;
        kind_nx = kind_q;
        hit_nx  = hit_q;
        tgt_nx  = tgt_q;
        unique case (st)
            ST_IDLE:
                if (req_valid)
                    st_nx = (row_rd == '0) ? ST_REMOTE : ST_LOCAL;
            ST_LOCAL:
                if (|loc_hits) begin
                    st_nx   = ST_RESP;
                    kind_nx = RES_LOCAL;
                    hit_nx  = lowest(loc_hits);
                end else begin
                    st_nx = ST_REMOTE;
                end
            ST_REMOTE: begin
                tgt_nx = pick_idx;
                if (|rem_hits) begin
                    st_nx   = ST_RESP;
                    kind_nx = RES_REMOTE;
                    hit_nx  = lowest(rem_hits);
                end else begin
                    st_nx = ST_MEM;
                end
            end
            ST_MEM:
                if (mem_ack) begin
                    st_nx   = ST_RESP;
                    kind_nx = RES_MISS;
                end
            ST_RESP:
                st_nx = ST_IDLE;
            default:
                st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready   = (st == ST_IDLE);
        split_addr  = addr_q;
        mem_addr    = addr_q;
        mem_req     = (st == ST_MEM);
        unique case (st)
            ST_LOCAL:  split_cs = row_q;
            ST_REMOTE: split_cs = ~row_q;
            default:   split_cs = '0;
        endcase
        rsp_valid   = (st == ST_RESP);
        rsp_kind    = kind_q;
        rsp_split   = (kind_q == RES_LOCAL) ? hit_q : tgt_q;
        fill_en     = (st == ST_RESP) && (kind_q != RES_LOCAL);
        fill_split  = tgt_q;
        evict_en    = (st == ST_RESP) && (kind_q == RES_REMOTE);
        evict_split = hit_q;
    end

    // R5
    probe_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|split_cs) && (|$past(split_cs))) |-> ((split_cs & $past(split_cs)) == '0));

    // R6
    mem_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past((split_cs != '0) && ((split_hit & split_cs) == '0)));

    // R7
    fill_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> ((row_q == '0) || row_q[fill_split]));

    // R8
    evict_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evict_en |-> (fill_en && ((row_q == '0) || !row_q[evict_split])));

    // R2
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));
endmodule

// File: tb/sim_split_lookup_ctrl.sv
`timescale 1ns/100ps
module sim_split_lookup_ctrl;
    localparam int NCPU = 4, NSPLIT = 8, AW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_cpu = '0;
    logic [7:0] cfg_mask = '0;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_cpu = '0;
    logic [15:0] req_addr = '0;
    logic [7:0] split_cs, split_hit;
    logic [15:0] split_addr, mem_addr;
    logic mem_req, mem_ack;
    logic fill_en, evict_en, rsp_valid;
    logic [2:0] fill_split, evict_split, rsp_split;
    logic [1:0] rsp_kind;

    split_lookup_ctrl #(.NCPU(NCPU), .NSPLIT(NSPLIT), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cpu(cfg_cpu), .cfg_mask(cfg_mask),
        .req_valid(req_valid), .req_ready(req_ready), .req_cpu(req_cpu), .req_addr(req_addr),
        .split_cs(split_cs), .split_addr(split_addr), .split_hit(split_hit),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .fill_en(fill_en), .fill_split(fill_split), .evict_en(evict_en), .evict_split(evict_split),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_split(rsp_split)
    );

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0, acc_cyc = 0, n_done = 0;
    bit finished = 1'b0;
    logic [7:0] tb_row [4];
    logic [7:0] fills_seen = '0;

    // split array model: block address and split for each stored block
    logic [15:0] ma [32];
    logic [2:0]  ms [32];
    bit          mv [32];

    // scoreboard queues
    int q_kind[$], q_loc[$], q_lat[$];
    logic [7:0] q_mask[$];
    logic [15:0] q_addr[$];

    always @(posedge clk) cyc <= cyc + 1;

    always_comb begin
        split_hit = '0;
        for (int k = 0; k < 32; k++)
            if (mv[k] && ma[k] == split_addr && split_cs[ms[k]])
                split_hit[ms[k]] = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int find(input logic [15:0] a);
        for (int k = 0; k < 32; k++)
            if (mv[k] && ma[k] == a) return int'(ms[k]);
        return -1;
    endfunction

    function automatic bit in_mask(input logic [7:0] m, input logic [2:0] s);
        return (m == '0) || m[s];
    endfunction

    // off-chip responder: acknowledge two cycles after a request appears
    initial begin
        mem_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ack) begin
                @(negedge clk);
                @(negedge clk);
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    // monitor: pop expectation and compare
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            int kind, loc, lat;
            logic [7:0] m;
            logic [15:0] a;
            kind = q_kind.pop_front(); loc = q_loc.pop_front(); lat = q_lat.pop_front();
            m = q_mask.pop_front(); a = q_addr.pop_front();
            chk(int'(rsp_kind) == kind, "R3/R5/R6 kind", int'(rsp_kind), kind);
            if (lat > 0)
                chk(cyc - acc_cyc == lat, "R3/R5/R9 latency", cyc - acc_cyc, lat);
            if (kind == 0) begin
                chk(int'(rsp_split) == loc, "R3 local split", int'(rsp_split), loc);
                chk(!fill_en && !evict_en, "R3 no movement", int'(fill_en), 0);
            end else if (kind == 1) begin
                chk(evict_en && int'(evict_split) == loc, "R8 evict split", int'(evict_split), loc);
                chk(fill_en && in_mask(m, fill_split), "R8 fill owned", int'(fill_split), int'(m));
                chk(rsp_split == fill_split, "R8 rsp split", int'(rsp_split), int'(fill_split));
            end else begin
                chk(fill_en && !evict_en, "R7 fill only", int'(evict_en), 0);
                chk(in_mask(m, fill_split), "R7 fill owned", int'(fill_split), int'(m));
                chk(rsp_split == fill_split, "R7 rsp split", int'(rsp_split), int'(fill_split));
            end
            if (evict_en)
                for (int k = 0; k < 32; k++)
                    if (mv[k] && ma[k] == a && ms[k] == evict_split) mv[k] = 1'b0;
            if (fill_en) begin
                fills_seen[fill_split] = 1'b1;
                for (int k = 0; k < 32; k++)
                    if (!mv[k]) begin
                        mv[k] = 1'b1; ma[k] = a; ms[k] = fill_split;
                        break;
                    end
            end
            n_done++;
        end
    end

    task automatic set_row(input int cpu, input logic [7:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_cpu = 2'(cpu); cfg_mask = m;
        @(negedge clk);
        cfg_we = 1'b0;
        tb_row[cpu] = m;
    endtask

    // driver: compute expectation, push it, run the request
    task automatic xact(input int cpu, input logic [15:0] a, input bit wr, input logic [7:0] wm);
        int loc, kind, lat, target;
        loc = find(a);
        if (loc >= 0 && tb_row[cpu][loc]) kind = 0;
        else if (loc >= 0) kind = 1;
        else kind = 2;
        lat = (kind == 0) ? 1 : (kind == 1) ? ((tb_row[cpu] == '0) ? 1 : 2) : 0;
        q_kind.push_back(kind); q_loc.push_back(loc); q_lat.push_back(lat);
        q_mask.push_back(tb_row[cpu]); q_addr.push_back(a);
        target = n_done + 1;
        @(negedge clk);
        req_valid = 1'b1; req_cpu = 2'(cpu); req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        acc_cyc = cyc;
        chk(req_ready == 1'b0, "R2 busy", int'(req_ready), 0);
        if (wr) begin
            // R10: rewrite this processor's mask while its lookup runs
            cfg_we = 1'b1; cfg_cpu = 2'(cpu); cfg_mask = wm;
            tb_row[cpu] = wm;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        wait (n_done >= target);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready again", int'(req_ready), 1);
    endtask

    initial begin
        for (int k = 0; k < 32; k++) begin mv[k] = 1'b0; ma[k] = '0; ms[k] = '0; end
        for (int c = 0; c < 4; c++) tb_row[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(!rsp_valid && !mem_req && !fill_en && !evict_en, "R1 idle outputs", int'(rsp_valid), 0);
        chk(split_cs == '0, "R1 cs", int'(split_cs), 0);
        // R1/R9: masks reset empty, so a first request probes all splits at once
        q_kind.push_back(2); q_loc.push_back(-1); q_lat.push_back(0);
        q_mask.push_back(8'h00); q_addr.push_back(16'h0F00);
        @(negedge clk);
        req_valid = 1'b1; req_cpu = 2'd2; req_addr = 16'h0F00;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(split_cs == 8'hFF, "R1/R9 empty mask probes all", int'(split_cs), 255);
        wait (n_done >= 1);
        @(negedge clk);

        set_row(0, 8'h01);
        set_row(1, 8'h06);
        set_row(2, 8'h06);
        set_row(3, 8'h00);

        xact(0, 16'h0100, 1'b0, '0);          // R6 R7 miss, fill split 0
        chk(find(16'h0100) == 0, "R7 fill exact", find(16'h0100), 0);
        xact(0, 16'h0100, 1'b0, '0);          // R3 local hit
        xact(1, 16'h0100, 1'b0, '0);          // R5 R8 remote hit, migrate
        xact(2, 16'h0100, 1'b0, '0);          // R4 shared split local hit
        xact(1, 16'h0100, 1'b0, '0);          // R8 now local for migrated owner
        xact(3, 16'h0100, 1'b0, '0);          // R9 empty mask remote hit
        xact(3, 16'h0200, 1'b0, '0);          // R9 miss with empty mask

        // R10: deferred table write
        xact(0, 16'h0300, 1'b0, '0);
        xact(0, 16'h0300, 1'b1, 8'h02);       // still local with old mask
        xact(0, 16'h0300, 1'b0, '0);          // now remote, fill into split 1
        chk(find(16'h0300) == 1, "R10 new mask applied", find(16'h0300), 1);

        // R11: spread of fill destinations
        set_row(1, 8'hF0);
        fills_seen = '0;
        for (int i = 0; i < 12; i++) begin
            xact(1, 16'h1000 + 16'(i), 1'b0, '0);
            repeat (i % 3) @(negedge clk);
        end
        chk(($countones(fills_seen) >= 2) && ((fills_seen & 8'h0F) == '0),
            "R11 spread", $countones(fills_seen), 2);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule